// File: doc/BRIEF.md
# Boundary Spin Exchange Controller

This block sits at the edge of one partition of a distributed Ising sampler. It carries the states of the p-bits that border a neighbouring partition. Only single state bits cross the link. The couplings on edges that cross the partition are duplicated on both sides, so no weight value is ever sent. For every exchange, the block captures the local boundary states into a snapshot. It shifts that snapshot out on a serial valid/ready link, one bit per boundary p-bit. At the same time it assembles the neighbour's bits, arriving on a second serial link, into a shadow register. The local sampler reads the shadow register as the field contribution from the other side.

A programmable interval k sets how many local sweeps the shadow values stay fixed before the next exchange replaces them. With k = 1 the block exchanges after every sweep, which matches an unpartitioned sampler. Larger k trades boundary staleness for fewer stalls. The local update rate and the link rate are independent. To keep local updates from running ahead of the boundary refreshes, the block raises `stall` from the end of each interval until both directions of the exchange are finished.

The control state machine has three states:
- BOOT: the single cycle after reset. It captures the first snapshot and starts the first exchange.
- XCHG: stalled while the exchange runs.
- RUN: sampling proceeds and sweeps are counted.

Its transitions are:
- BOOT→XCHG: always.
- XCHG→RUN: when the serializer and deserializer are both idle.
- RUN→XCHG: on the sweep-done pulse that closes the interval.

The serializer has two states, IDLE and SEND:
- IDLE→SEND: on the start pulse.
- SEND→IDLE: on the handshake of the last bit.

The deserializer has two states, IDLE and RECV:
- IDLE→RECV: on the start pulse.
- RECV→IDLE: on the handshake of a well-formed frame's last bit.

Top module: `bnd_xchg_ctrl`

## Requirements
- R1: While reset is asserted, `stall` is 1, `shadow_bits` is all zeros and `tx_valid` is 0. After reset is released, the first exchange sends the `local_bits` value present in the first cycle after release. `stall` stays 1 until that exchange completes.
- R2: An outgoing frame is NB bits, sent bit 0 first, one bit per accepted handshake (`tx_valid` and `tx_ready` both 1 at a rising edge). `tx_last` is 1 only with bit NB-1. `tx_data` and `tx_last` hold steady while `tx_valid` waits for `tx_ready`.
- R3: The outgoing frame equals `local_bits` as sampled on the sweep-done pulse that closes the interval. Later changes of `local_bits` do not alter it.
- R4: `shadow_bits` changes only on the accepted handshake that carries `rx_last` with the NB-th bit of a frame. It then takes all NB received bits at once, with bit 0 being the first received. Mid-frame, it keeps its previous value.
- R5: A malformed incoming frame is discarded and the bit count restarts, leaving `shadow_bits` unchanged. A frame is malformed when `rx_last` arrives before the NB-th bit, or when the NB-th bit arrives without `rx_last`.
- R6: With interval k = `cfg_interval`, where the value 0 is treated as 1, `stall` stays 0 through the first k-1 sweep-done pulses counted after an exchange. It becomes 1 in the cycle after the k-th pulse.
- R7: `stall` stays 1 until both the outgoing and the incoming frame of the current exchange are complete. It returns to 0 one cycle after the later of the two. While `stall` is 0, `tx_valid` and `rx_ready` are 0.
- R8: Sweep-done pulses that arrive while `stall` is 1 are not counted toward the next interval.
- R9: With k = 1, every sweep-done pulse starts an exchange. This holds for every combination of outgoing snapshot and incoming frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | KW | Sweeps per exchange (0 acts as 1) |
| local_bits | input | NB | Current local boundary p-bit states |
| sweep_done | input | 1 | One-cycle pulse at the end of each local sweep |
| stall | output | 1 | Hold local sampling |
| shadow_bits | output | NB | Last complete set of neighbour boundary states |
| tx_valid | output | 1 | Outgoing bit available |
| tx_ready | input | 1 | Neighbour accepts outgoing bit |
| tx_data | output | 1 | Outgoing state bit |
| tx_last | output | 1 | Marks the final bit of an outgoing frame |
| rx_valid | input | 1 | Incoming bit available |
| rx_ready | output | 1 | Block accepts incoming bit |
| rx_data | input | 1 | Incoming state bit |
| rx_last | input | 1 | Marks the final bit of an incoming frame |

## Verification
The bench builds the block with NB = 4 and KW = 3. This makes all 16 outgoing snapshots and all 16 incoming frames reachable at k = 1, and lets every interval from 0 (acting as 1) up to 4 be swept. Its link model throttles `tx_ready` and `rx_valid` in patterns that shift from one exchange to the next, so frames finish in either order. Two kinds of malformed frame are injected before a good one to show discard and continued stalling.

// File: rtl/bx_pkg.sv
package bx_pkg;
    typedef enum logic [1:0] {
        BX_BOOT = 2'd0,
        BX_XCHG = 2'd1,
        BX_RUN  = 2'd2
    } bx_state_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_e;
endpackage

// File: rtl/bx_pace.sv
module bx_pace
    import bx_pkg::*;
#(
    parameter int KW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [KW-1:0] cfg_interval,
    input  logic          sweep_done,
    input  logic          tx_busy,
    input  logic          rx_busy,
    output logic          stall,
    output logic          start
);
    localparam int CW = KW + 1;

    bx_state_e     state_q, state_d;
    logic [KW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] k_eff;
    logic [CW-1:0] cnt_inc;
    logic          hit;

    // interval of zero is treated as one sweep
    assign k_eff   = (cfg_interval == '0) ? CW'(1) : {1'b0, cfg_interval};
    assign cnt_inc = {1'b0, cnt_q} + CW'(1);
    assign hit     = (cnt_inc >= k_eff);

    // next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BX_BOOT: begin
                state_d = BX_XCHG;
                cnt_d   = '0;
            end
            BX_XCHG: begin
                cnt_d = '0;
                if (!tx_busy && !rx_busy) begin
                    state_d = BX_RUN;
                end
            end
            BX_RUN: begin
                if (sweep_done) begin
                    if (hit) begin
                        state_d = BX_XCHG;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[KW-1:0];
                    end
                end
            end
            default: begin
                state_d = BX_BOOT;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BX_BOOT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        stall = 1'b1;
        start = 1'b0;
        unique case (state_q)
            BX_BOOT: begin
                stall = 1'b1;
                start = 1'b1;
            end
            BX_XCHG: begin
                stall = 1'b1;
                start = 1'b0;
            end
            BX_RUN: begin
                stall = 1'b0;
                start = sweep_done && hit;
            end
            default: begin
                stall = 1'b1;
                start = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bx_tx_ser.sv
module bx_tx_ser
    import bx_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NB-1:0] local_bits,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic          tx_data,
    output logic          tx_last,
    output logic          busy
);
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

    tx_state_e     state_q, state_d;
    logic [NB-1:0] snap_q;
    logic [IW-1:0] idx_q, idx_d;
    logic          fire;
    logic          at_end;

    assign at_end = (idx_q == LAST_IDX);
    assign fire   = (state_q == TX_SEND) && tx_ready;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            TX_IDLE: begin
                if (start) begin
                    state_d = TX_SEND;
                    idx_d   = '0;
                end
            end
            TX_SEND: begin
                if (fire) begin
                    if (at_end) begin
                        state_d = TX_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IW'(1);
                    end
                end
            end
            default: begin
                state_d = TX_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            idx_q   <= '0;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (start && (state_q == TX_IDLE)) begin
                snap_q <= local_bits;
            end
        end
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        busy     = 1'b0;
        tx_data  = snap_q[idx_q];
        unique case (state_q)
            TX_IDLE: begin
                tx_valid = 1'b0;
                tx_last  = 1'b0;
                busy     = 1'b0;
            end
            TX_SEND: begin
                tx_valid = 1'b1;
                tx_last  = at_end;
                busy     = 1'b1;
            end
            default: begin
                tx_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bx_rx_des.sv
module bx_rx_des
    import bx_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rx_valid,
    input  logic          rx_data,
    input  logic          rx_last,
    output logic          rx_ready,
    output logic [NB-1:0] shadow_bits,
    output logic          busy
);
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

    rx_state_e     state_q, state_d;
    logic [NB-1:0] rbuf_q;
    logic [NB-1:0] frame_nxt;
    logic [NB-1:0] shadow_q;
    logic [IW-1:0] cnt_q, cnt_d;
    logic          take;
    logic          at_end;
    logic          good_end;

    assign take     = (state_q == RX_RECV) && rx_valid;
    assign at_end   = (cnt_q == LAST_IDX);
    assign good_end = take && rx_last && at_end;

    always_comb begin
        frame_nxt        = rbuf_q;
        frame_nxt[cnt_q] = rx_data;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RX_IDLE: begin
                if (start) begin
                    state_d = RX_RECV;
                    cnt_d   = '0;
                end
            end
            RX_RECV: begin
                if (take) begin
                    if (good_end) begin
                        state_d = RX_IDLE;
                        cnt_d   = '0;
                    end else if (rx_last || at_end) begin
                        // malformed frame: drop it and start over
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + IW'(1);
                    end
                end
            end
            default: begin
                state_d = RX_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RX_IDLE;
            cnt_q    <= '0;
            rbuf_q   <= '0;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (take) begin
                rbuf_q <= frame_nxt;
            end
            if (good_end) begin
                shadow_q <= frame_nxt;
            end
        end
    end

    always_comb begin
        rx_ready = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                rx_ready = 1'b0;
                busy     = 1'b0;
            end
            RX_RECV: begin
                rx_ready = 1'b1;
                busy     = 1'b1;
            end
            default: begin
                rx_ready = 1'b0;
            end
        endcase
    end

    assign shadow_bits = shadow_q;
endmodule

// File: rtl/bnd_xchg_ctrl.sv
module bnd_xchg_ctrl #(
    parameter int NB = 8,
    parameter int KW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [KW-1:0] cfg_interval,
    input  logic [NB-1:0] local_bits,
    input  logic          sweep_done,
    output logic          stall,
    output logic [NB-1:0] shadow_bits,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          tx_data,
    output logic          tx_last,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic          rx_data,
    input  logic          rx_last
);
    logic start;
    logic tx_busy;
    logic rx_busy;

    bx_pace #(.KW(KW)) u_pace (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_interval (cfg_interval),
        .sweep_done   (sweep_done),
        .tx_busy      (tx_busy),
        .rx_busy      (rx_busy),
        .stall        (stall),
        .start        (start)
    );

    bx_tx_ser #(.NB(NB)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .local_bits (local_bits),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .busy       (tx_busy)
    );

    bx_rx_des #(.NB(NB)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_last     (rx_last),
        .rx_ready    (rx_ready),
        .shadow_bits (shadow_bits),
        .busy        (rx_busy)
    );
endmodule

// File: rtl/bx_chk.sv
module bx_chk #(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sweep_done,
    input logic          stall,
    input logic [NB-1:0] shadow_bits,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          tx_data,
    input logic          tx_last,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          rx_last
);
    assert_link_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> (!tx_valid && !rx_ready));

    assert_last_with_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_hold_while_waiting_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_shadow_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shadow_bits) |-> $past(rx_valid && rx_ready && rx_last));

    assert_stall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(sweep_done));
endmodule

bind bnd_xchg_ctrl bx_chk #(.NB(NB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sweep_done  (sweep_done),
    .stall       (stall),
    .shadow_bits (shadow_bits),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_last     (rx_last)
);

// File: tb/bnd_xchg_ctrl_bench.sv
`timescale 1ns/1ps
module bnd_xchg_ctrl_bench;
    localparam int NB = 4;
    localparam int KW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [KW-1:0] cfg_interval = '0;
    logic [NB-1:0] local_bits = '0;
    logic          sweep_done = 1'b0;
    logic          stall;
    logic [NB-1:0] shadow_bits;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic          tx_data;
    logic          tx_last;
    logic          rx_valid = 1'b0;
    logic          rx_ready;
    logic          rx_data = 1'b0;
    logic          rx_last = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int pat = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bnd_xchg_ctrl #(.NB(NB), .KW(KW)) u_bnd_xchg_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_interval (cfg_interval),
        .local_bits   (local_bits),
        .sweep_done   (sweep_done),
        .stall        (stall),
        .shadow_bits  (shadow_bits),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_data      (tx_data),
        .tx_last      (tx_last),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .rx_data      (rx_data),
        .rx_last      (rx_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_sweep();
        @(negedge clk);
        sweep_done = 1'b1;
        @(negedge clk);
        sweep_done = 1'b0;
    endtask

    // drive n bits of data, marking rx_last on index last_idx (-1: never)
    task automatic send_bits(input logic [NB-1:0] data, input int n, input int last_idx,
                             input bit mid, input logic [NB-1:0] old_sh);
        int i = 0;
        int c = 0;
        bit midded = 1'b0;
        while (i < n) begin
            @(negedge clk);
            if (mid && !midded && (i == n - 1)) begin
                chk("R4 shadow held mid-frame", 32'(shadow_bits), 32'(old_sh));
                midded = 1'b1;
            end
            rx_valid = ((c + pat) % 4) != 2;
            rx_data  = data[i];
            rx_last  = (i == last_idx);
            c++;
            #1;
            if (rx_valid && rx_ready) i++;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic exchange(input string tag, input logic [NB-1:0] rxv,
                            input logic [NB-1:0] exp_tx, input int bad);
        logic [NB-1:0] got = '0;
        logic [NB-1:0] old_sh = shadow_bits;
        int w = 0;
        fork
            begin
                int i = 0;
                int c = 0;
                while (i < NB) begin
                    @(negedge clk);
                    tx_ready = ((c + pat) % 3) != 1;
                    c++;
                    #1;
                    if (tx_valid && tx_ready) begin
                        got[i] = tx_data;
                        chk("R2 tx_last position", 32'(tx_last), 32'(i == NB - 1));
                        i++;
                    end
                end
                @(negedge clk);
                tx_ready = 1'b0;
            end
            begin
                if (bad == 1) begin
                    send_bits(~rxv, 2, 1, 1'b0, old_sh);
                    chk("R5 early last discarded", 32'(shadow_bits), 32'(old_sh));
                    chk("R7 stall held while rx pending", 32'(stall), 32'd1);
                end else if (bad == 2) begin
                    send_bits(~rxv, NB, -1, 1'b0, old_sh);
                    chk("R5 missing last discarded", 32'(shadow_bits), 32'(old_sh));
                    chk("R7 stall held while rx pending", 32'(stall), 32'd1);
                end
                send_bits(rxv, NB, NB - 1, 1'b1, old_sh);
                chk("R4 shadow after frame", 32'(shadow_bits), 32'(rxv));
            end
        join
        chk(tag, 32'(got), 32'(exp_tx));
        while (stall && w < 6) begin
            @(negedge clk);
            w++;
        end
        chk("R7 stall released", 32'(stall), 32'd0);
        chk("R7 link idle when running", 32'({tx_valid, rx_ready}), 32'd0);
        pat++;
    endtask

    // one interval of k sweeps, then an exchange
    task automatic interval(input int cfg, input int k, input logic [NB-1:0] rxv, input int bad);
        logic [NB-1:0] snap = '0;
        cfg_interval = KW'(cfg);
        for (int j = 0; j < k; j++) begin
            local_bits = NB'(j * 5 + pat * 3 + 1);
            snap = local_bits;
            pulse_sweep();
            if (j < k - 1) chk("R6 no stall before interval end", 32'(stall), 32'd0);
            else           chk("R6 stall at interval end", 32'(stall), 32'd1);
        end
        local_bits = ~snap;
        // pulses while stalled must not count (R8)
        pulse_sweep();
        pulse_sweep();
        exchange("R3 snapshot sent", rxv, snap, bad);
    endtask

    initial begin
        local_bits   = 4'hB;
        cfg_interval = 3'd2;
        repeat (3) @(negedge clk);
        chk("R1 stall in reset", 32'(stall), 32'd1);
        chk("R1 shadow zero in reset", 32'(shadow_bits), 32'd0);
        chk("R1 tx idle in reset", 32'(tx_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stall before first exchange", 32'(stall), 32'd1);
        exchange("R1 first frame", 4'h6, 4'hB, 0);

        for (int k = 1; k <= 4; k++) begin
            interval(k, k, NB'(k * 3 + 2), k % 3);
        end
        // count reset check R8: k=2 after stalled pulses
        interval(2, 2, 4'h9, 0);
        // zero interval behaves as one
        interval(0, 1, 4'h5, 0);

        // R9: exhaustive at k = 1
        cfg_interval = 3'd1;
        for (int v = 0; v < 16; v++) begin
            local_bits = NB'(v);
            pulse_sweep();
            chk("R9 stall every sweep", 32'(stall), 32'd1);
            local_bits = NB'(~v);
            exchange("R9 frame", NB'(15 - v), NB'(v), (v == 7) ? 2 : 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule